// File: doc/BRIEF.md
# Configurable GMII Ethernet Frame Generator

This block drives complete Ethernet frames onto an 8-bit GMII-style transmit interface (one octet per clock with a data-valid and an error strobe). A one-cycle start request launches one frame. At that moment the block takes a snapshot of its configuration inputs: both addresses and their byte order, preamble length, payload-length sequencing, length/type override, padding, VLAN tag and the fault-injection options. The frame consists of the preamble and start delimiter, the address header, an optional VLAN tag, the length/type field, a counting payload, optional zero padding and the CRC-32 frame check sequence. A programmable idle gap follows.

A verification environment uses it as a stimulus source for a MAC receive path. Payload lengths advance from frame to frame through a start/step/maximum sequence. Deliberate faults let the receiving side be tested against corrupted payloads, preambles and check sequences, PHY error strobes and a late drop of data valid. A `ready` output tells the environment when the next start will be taken.

Top module: `eth_frame_gen`

## Requirements
- R1: A frame is sent in this order: `preamble_len` octets of 0x55, one 0xD5 delimiter, 6 destination octets, 6 source octets, the optional 4-octet VLAN tag, 2 length/type octets (high octet first), the payload, the padding and 4 check octets. Payload octet i (counting from 0) has the value i modulo 256. A `preamble_len` of 0 sends the delimiter first.
- R2: After reset, the first frame's payload length is `len_start`. Each later frame uses previous + `len_step`, and when that sum exceeds `len_max` the length becomes 0.
- R3: A nonzero `type_override` is sent in the length/type field. When it is zero, the payload length is sent there.
- R4: With `addr_msb_first` low, each address is sent bits [7:0] first and bits [47:40] last. With it high, the order is reversed.
- R5: With `pad_en` high, zero octets follow the payload until the octets from the destination address through the padding number at least 60, which makes 64 with the check field. No padding is added when the count is already 60 or more.
- R6: With `vlan_en` high, the octets 0x81, 0x00, `vlan_ctl[15:8]`, `vlan_ctl[7:0]` follow the source address.
- R7: The check field is the reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones, result complemented) over the destination address through the last pad octet, sent least significant octet first. `err_crc` inverts every check octet.
- R8: `err_payload` inverts the last payload octet on the wire while the check field still covers the unaltered octet. `err_preamble` sends every preamble octet as 0xAA.
- R9: `tx_er` is high on exactly the frame's `tx_dv` cycles when `err_phy` is set, and low otherwise. `err_late_end` holds `tx_dv` high for one more cycle after the last octet, with data 0x00.
- R10: `data_only` leaves out the preamble, the delimiter, the padding and the check field.
- R11: `ready` is high when idle and low from the accepting edge until the gap ends. A start while `ready` is low is ignored. When a start is waiting, exactly max(`ipg_len`,1) cycles of `tx_dv` low separate two frames.
- R12: A start sampled with `ready` high places the first octet on the outputs two rising edges later. All configuration is captured at the accepting edge, so later input changes do not alter the frame in progress.
- R13: During and after reset, `tx_d` is 0, `tx_dv` and `tx_er` are low and `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame launch request |
| dst_addr | input | 48 | Destination address |
| src_addr | input | 48 | Source address |
| addr_msb_first | input | 1 | Send address octets high first |
| preamble_len | input | PRE_W (4) | Preamble octet count |
| len_start | input | LEN_W (11) | First payload length |
| len_step | input | LEN_W (11) | Payload length increment |
| len_max | input | LEN_W (11) | Payload length ceiling |
| type_override | input | 16 | Length/type replacement when nonzero |
| pad_en | input | 1 | Pad short frames |
| vlan_en | input | 1 | Insert VLAN tag |
| vlan_ctl | input | 16 | VLAN control word |
| err_payload | input | 1 | Corrupt last payload octet |
| err_preamble | input | 1 | Corrupt preamble octets |
| err_crc | input | 1 | Invert check octets |
| err_phy | input | 1 | Raise tx_er during the frame |
| err_late_end | input | 1 | Keep tx_dv one extra cycle |
| data_only | input | 1 | Omit preamble, delimiter, pad, check |
| ipg_len | input | IPG_W (8) | Inter-frame gap in cycles |
| ready | output | 1 | Next start will be accepted |
| tx_d | output | 8 | Transmit octet |
| tx_dv | output | 1 | Transmit data valid |
| tx_er | output | 1 | Transmit error strobe |

## Verification
A wrong segment counter or a mis-chosen successor segment shifts every later octet. The per-cycle comparison catches it at the first misplaced octet, and the check field confirms it four octets after the padding. A wrong CRC register or a wrong length-sequence state shows only in the check field or in the next frame's length/type octets, so every frame is compared in full and several lengths are run back to back. A wrong gap counter shows as `ready` or `tx_dv` rising one cycle early or late after the last octet.

// File: rtl/efg_pkg.sv
package efg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_SFD, ST_DA, ST_SA, ST_VTAG,
    ST_LT, ST_PAY, ST_PAD, ST_FCS, ST_EXT, ST_GAP
  } seg_e;

  localparam int ADDR_BYTES  = 6;
  localparam int ADDR_W      = 8 * ADDR_BYTES;
  localparam int MIN_COVERED = 60;
  localparam int FCS_BYTES   = 4;

  localparam logic [7:0]  PRE_OCTET = 8'h55;
  localparam logic [7:0]  PRE_BAD   = 8'hAA;
  localparam logic [7:0]  SFD_OCTET = 8'hD5;
  localparam logic [15:0] VLAN_TPID = 16'h8100;
  localparam logic [31:0] CRC_REFL  = 32'hEDB88320;

  // one octet through the reflected CRC-32, LSB of the octet first
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ CRC_REFL) : (r >> 1);
    return r;
  endfunction

  // fixed order of frame segments
  function automatic seg_e seg_succ(input seg_e s);
    case (s)
      ST_PRE:  return ST_SFD;
      ST_SFD:  return ST_DA;
      ST_DA:   return ST_SA;
      ST_SA:   return ST_VTAG;
      ST_VTAG: return ST_LT;
      ST_LT:   return ST_PAY;
      ST_PAY:  return ST_PAD;
      ST_PAD:  return ST_FCS;
      ST_FCS:  return ST_EXT;
      ST_EXT:  return ST_GAP;
      default: return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/efg_len_seq.sv
module efg_len_seq #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [LEN_W-1:0] len_start,
  input  logic [LEN_W-1:0] len_step,
  input  logic [LEN_W-1:0] len_max,
  output logic [LEN_W-1:0] cur_len
);
  logic             first_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W:0]   sum;

  assign cur_len = first_q ? len_start : len_q;
  assign sum     = {1'b0, cur_len} + {1'b0, len_step};

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b1;
      len_q   <= '0;
    end else if (advance) begin
      first_q <= 1'b0;
      len_q   <= (sum > {1'b0, len_max}) ? '0 : sum[LEN_W-1:0];
    end
  end

  // R2
  len_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    advance |=> (cur_len <= $past(len_max)));

endmodule

// File: rtl/efg_crc32.sv
module efg_crc32 import efg_pkg::*; #(
  parameter int CRC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic [7:0]       din,
  output logic [CRC_W-1:0] fcs_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= '1;
    else if (en)      crc_q <= crc_step(crc_q, din);
  end

  assign fcs_o = ~crc_q;

  // R7
  crc_seed_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (fcs_o == '0));

endmodule

// File: rtl/efg_seq.sv
module efg_seq import efg_pkg::*; #(
  parameter int PRE_W = 4,
  parameter int IPG_W = 8,
  parameter int LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic              addr_msb_first,
  input  logic [PRE_W-1:0]  preamble_len,
  input  logic [15:0]       type_override,
  input  logic              pad_en,
  input  logic              vlan_en,
  input  logic [15:0]       vlan_ctl,
  input  logic              err_payload,
  input  logic              err_preamble,
  input  logic              err_crc,
  input  logic              err_phy,
  input  logic              err_late_end,
  input  logic              data_only,
  input  logic [IPG_W-1:0]  ipg_len,
  input  logic [LEN_W-1:0]  pay_len,
  input  logic [31:0]       fcs_i,
  output logic              accept_o,
  output logic              ready_o,
  output logic              crc_en_o,
  output logic [7:0]        crc_oct_o,
  output logic [7:0]        oct_o,
  output logic              dv_o,
  output logic              er_o
);
  typedef struct packed {
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
    logic              msb_first;
    logic [PRE_W-1:0]  pre_len;
    logic [15:0]       type_ovr;
    logic              pad_en;
    logic              vlan_en;
    logic [15:0]       vlan_ctl;
    logic              e_pay;
    logic              e_pre;
    logic              e_crc;
    logic              e_phy;
    logic              e_late;
    logic              data_only;
    logic [IPG_W-1:0]  ipg;
    logic [LEN_W-1:0]  len;
  } cfg_t;

  function automatic logic [LEN_W-1:0] pad_of(input cfg_t c);
    int hdr, tot;
    hdr = c.vlan_en ? 18 : 14;
    tot = hdr + int'(c.len);
    if (c.pad_en && !c.data_only && tot < MIN_COVERED) return LEN_W'(MIN_COVERED - tot);
    return '0;
  endfunction

  function automatic logic [LEN_W-1:0] seg_len(input seg_e s, input cfg_t c);
    case (s)
      ST_PRE:       return c.data_only ? '0 : LEN_W'(c.pre_len);
      ST_SFD:       return c.data_only ? '0 : LEN_W'(1);
      ST_DA, ST_SA: return LEN_W'(ADDR_BYTES);
      ST_VTAG:      return c.vlan_en ? LEN_W'(4) : '0;
      ST_LT:        return LEN_W'(2);
      ST_PAY:       return c.len;
      ST_PAD:       return pad_of(c);
      ST_FCS:       return c.data_only ? '0 : LEN_W'(FCS_BYTES);
      ST_EXT:       return c.e_late ? LEN_W'(1) : '0;
      default:      return LEN_W'(1);
    endcase
  endfunction

  // first segment at or after s0 that carries at least one octet
  function automatic seg_e settle(input seg_e s0, input cfg_t c);
    seg_e s;
    s = s0;
    for (int k = 0; k < 12; k++)
      if (s != ST_GAP && s != ST_IDLE && seg_len(s, c) == '0) s = seg_succ(s);
    return s;
  endfunction

  function automatic logic [7:0] addr_octet(input logic [ADDR_W-1:0] a,
                                            input logic [LEN_W-1:0] i, input logic msb);
    logic [7:0] r;
    int j;
    j = msb ? (ADDR_BYTES - 1 - int'(i)) : int'(i);
    r = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (k == j) r = a[8*k +: 8];
    return r;
  endfunction

  seg_e             state_q, nxt_state;
  logic [LEN_W-1:0] idx_q, cur_len;
  logic [IPG_W-1:0] gap_q;
  cfg_t             cfg_q, cfg_in;
  logic [15:0]      lt_val;
  logic [7:0]       oct_raw, oct_tx;

  always_comb begin
    cfg_in.dst       = dst_addr;
    cfg_in.src       = src_addr;
    cfg_in.msb_first = addr_msb_first;
    cfg_in.pre_len   = preamble_len;
    cfg_in.type_ovr  = type_override;
    cfg_in.pad_en    = pad_en;
    cfg_in.vlan_en   = vlan_en;
    cfg_in.vlan_ctl  = vlan_ctl;
    cfg_in.e_pay     = err_payload;
    cfg_in.e_pre     = err_preamble;
    cfg_in.e_crc     = err_crc;
    cfg_in.e_phy     = err_phy;
    cfg_in.e_late    = err_late_end;
    cfg_in.data_only = data_only;
    cfg_in.ipg       = ipg_len;
    cfg_in.len       = pay_len;
  end

  assign cur_len   = seg_len(state_q, cfg_q);
  assign nxt_state = settle(seg_succ(state_q), cfg_q);
  assign lt_val    = (cfg_q.type_ovr != 16'h0) ? cfg_q.type_ovr : 16'(cfg_q.len);

  always_comb begin
    oct_raw = 8'h00;
    oct_tx  = 8'h00;
    case (state_q)
      ST_PRE: oct_tx = cfg_q.e_pre ? PRE_BAD : PRE_OCTET;
      ST_SFD: oct_tx = SFD_OCTET;
      ST_DA:  oct_raw = addr_octet(cfg_q.dst, idx_q, cfg_q.msb_first);
      ST_SA:  oct_raw = addr_octet(cfg_q.src, idx_q, cfg_q.msb_first);
      ST_VTAG: begin
        case (idx_q[1:0])
          2'd0:    oct_raw = VLAN_TPID[15:8];
          2'd1:    oct_raw = VLAN_TPID[7:0];
          2'd2:    oct_raw = cfg_q.vlan_ctl[15:8];
          default: oct_raw = cfg_q.vlan_ctl[7:0];
        endcase
      end
      ST_LT:  oct_raw = (idx_q == '0) ? lt_val[15:8] : lt_val[7:0];
      ST_PAY: oct_raw = idx_q[7:0];
      ST_FCS: oct_tx = 8'(fcs_i >> {idx_q[1:0], 3'b000}) ^ {8{cfg_q.e_crc}};
      default: ;
    endcase
    if (state_q inside {ST_DA, ST_SA, ST_VTAG, ST_LT, ST_PAD}) oct_tx = oct_raw;
    if (state_q == ST_PAY)
      oct_tx = (cfg_q.e_pay && idx_q == cfg_q.len - 1'b1) ? ~oct_raw : oct_raw;
  end

  assign dv_o      = !(state_q inside {ST_IDLE, ST_GAP});
  assign er_o      = dv_o && cfg_q.e_phy;
  assign oct_o     = oct_tx;
  assign crc_en_o  = state_q inside {ST_DA, ST_SA, ST_VTAG, ST_LT, ST_PAY, ST_PAD};
  assign crc_oct_o = oct_raw;
  assign ready_o   = (state_q == ST_IDLE) || (state_q == ST_GAP && gap_q <= IPG_W'(1));
  assign accept_o  = ready_o && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      gap_q   <= '0;
      cfg_q   <= '0;
    end else if (accept_o) begin
      cfg_q   <= cfg_in;
      state_q <= settle(ST_PRE, cfg_in);
      idx_q   <= '0;
    end else if (state_q == ST_GAP) begin
      if (gap_q <= IPG_W'(1)) state_q <= ST_IDLE;
      else                    gap_q   <= gap_q - 1'b1;
    end else if (state_q != ST_IDLE) begin
      if (idx_q == cur_len - 1'b1) begin
        idx_q   <= '0;
        state_q <= nxt_state;
        if (nxt_state == ST_GAP) gap_q <= cfg_q.ipg;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R1
  sfd_then_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SFD) |=> (state_q == ST_DA));

  // R11
  gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GAP && gap_q > IPG_W'(1)) |=> (state_q == ST_GAP));

  // R7
  fcs_four_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FCS && idx_q == LEN_W'(FCS_BYTES - 1)) |=> (state_q != ST_FCS));

endmodule

// File: rtl/eth_frame_gen.sv
module eth_frame_gen import efg_pkg::*; #(
  parameter int PRE_W = 4,
  parameter int IPG_W = 8,
  parameter int LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [47:0]       dst_addr,
  input  logic [47:0]       src_addr,
  input  logic              addr_msb_first,
  input  logic [PRE_W-1:0]  preamble_len,
  input  logic [LEN_W-1:0]  len_start,
  input  logic [LEN_W-1:0]  len_step,
  input  logic [LEN_W-1:0]  len_max,
  input  logic [15:0]       type_override,
  input  logic              pad_en,
  input  logic              vlan_en,
  input  logic [15:0]       vlan_ctl,
  input  logic              err_payload,
  input  logic              err_preamble,
  input  logic              err_crc,
  input  logic              err_phy,
  input  logic              err_late_end,
  input  logic              data_only,
  input  logic [IPG_W-1:0]  ipg_len,
  output logic              ready,
  output logic [7:0]        tx_d,
  output logic              tx_dv,
  output logic              tx_er
);
  logic [LEN_W-1:0] pay_len;
  logic [31:0]      fcs;
  logic             accept_w, crc_en, dv_w, er_w;
  logic [7:0]       crc_oct, oct_w;

  efg_len_seq #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .advance(accept_w),
    .len_start(len_start), .len_step(len_step), .len_max(len_max),
    .cur_len(pay_len)
  );

  efg_crc32 #(.CRC_W(32)) u_crc (
    .clk(clk), .rst(rst), .clear(accept_w), .en(crc_en),
    .din(crc_oct), .fcs_o(fcs)
  );

  efg_seq #(.PRE_W(PRE_W), .IPG_W(IPG_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .dst_addr(dst_addr), .src_addr(src_addr), .addr_msb_first(addr_msb_first),
    .preamble_len(preamble_len), .type_override(type_override),
    .pad_en(pad_en), .vlan_en(vlan_en), .vlan_ctl(vlan_ctl),
    .err_payload(err_payload), .err_preamble(err_preamble), .err_crc(err_crc),
    .err_phy(err_phy), .err_late_end(err_late_end), .data_only(data_only),
    .ipg_len(ipg_len), .pay_len(pay_len), .fcs_i(fcs),
    .accept_o(accept_w), .ready_o(ready), .crc_en_o(crc_en), .crc_oct_o(crc_oct),
    .oct_o(oct_w), .dv_o(dv_w), .er_o(er_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_d  <= 8'h00;
      tx_dv <= 1'b0;
      tx_er <= 1'b0;
    end else begin
      tx_d  <= oct_w;
      tx_dv <= dv_w;
      tx_er <= er_w;
    end
  end

  // R12
  launch_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_dv) |-> $past(accept_w, 2));

  // R9
  er_within_dv_chk: assert property (@(posedge clk) disable iff (rst)
    tx_er |-> tx_dv);

endmodule

// File: tb/tb_eth_frame_gen.sv
module tb_eth_frame_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PRE_W = 4;
  localparam int IPG_W = 8;
  localparam int LEN_W = 11;

  logic             clk, rst, start;
  logic [47:0]      dst_addr, src_addr;
  logic             addr_msb_first, pad_en, vlan_en;
  logic [PRE_W-1:0] preamble_len;
  logic [LEN_W-1:0] len_start, len_step, len_max;
  logic [15:0]      type_override, vlan_ctl;
  logic             err_payload, err_preamble, err_crc, err_phy, err_late_end, data_only;
  logic [IPG_W-1:0] ipg_len;
  logic             ready, tx_dv, tx_er;
  logic [7:0]       tx_d;

  eth_frame_gen #(.PRE_W(PRE_W), .IPG_W(IPG_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst(rst), .start(start), .dst_addr(dst_addr), .src_addr(src_addr),
    .addr_msb_first(addr_msb_first), .preamble_len(preamble_len),
    .len_start(len_start), .len_step(len_step), .len_max(len_max),
    .type_override(type_override), .pad_en(pad_en), .vlan_en(vlan_en),
    .vlan_ctl(vlan_ctl), .err_payload(err_payload), .err_preamble(err_preamble),
    .err_crc(err_crc), .err_phy(err_phy), .err_late_end(err_late_end),
    .data_only(data_only), .ipg_len(ipg_len), .ready(ready),
    .tx_d(tx_d), .tx_dv(tx_dv), .tx_er(tx_er)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] q_d[$];
  logic       q_dv[$], q_er[$], q_rdy[$];
  string      q_tag[$];
  int  n_cmp = 0, n_bad = 0;
  logic last_rdy = 1'b1;
  bit   in_reset = 1'b1;
  bit   done = 1'b0;
  int   m_len = 0;
  bit   m_first = 1'b1;

  task automatic check_one(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(logic [7:0] d, logic dv, logic er, logic rdy, string tag);
    q_d.push_back(d); q_dv.push_back(dv); q_er.push_back(er);
    q_rdy.push_back(rdy); q_tag.push_back(tag);
  endtask

  task automatic step();
    logic [7:0] ed;
    logic edv, eer, erdy;
    string tg;
    @(negedge clk);
    if (q_d.size() > 0) begin
      ed = q_d.pop_front(); edv = q_dv.pop_front(); eer = q_er.pop_front();
      erdy = q_rdy.pop_front(); tg = q_tag.pop_front();
    end else begin
      ed = 8'h00; edv = 1'b0; eer = 1'b0; erdy = 1'b1;
      tg = in_reset ? "R13" : "R11";
    end
    check_one(tg, "tx_d", tx_d, ed);
    check_one(tg, "tx_dv", {7'b0, tx_dv}, {7'b0, edv});
    check_one("R9", "tx_er", {7'b0, tx_er}, {7'b0, eer});
    check_one("R11", "ready", {7'b0, ready}, {7'b0, erdy});
    last_rdy = erdy;
  endtask

  // behavioural model of one frame from the inputs present at acceptance
  task automatic model_frame();
    int plen, nxt, lastpay, gapn;
    logic [7:0] cov[$];
    logic [7:0] fd[$];
    string ft[$];
    logic [15:0] lt;
    logic [31:0] crc;
    plen = m_first ? int'(len_start) : m_len;
    nxt = plen + int'(len_step);
    m_len = (nxt > int'(len_max)) ? 0 : nxt;
    m_first = 1'b0;
    for (int k = 0; k < 6; k++) cov.push_back(addr_msb_first ? dst_addr[8*(5-k) +: 8] : dst_addr[8*k +: 8]);
    for (int k = 0; k < 6; k++) cov.push_back(addr_msb_first ? src_addr[8*(5-k) +: 8] : src_addr[8*k +: 8]);
    if (vlan_en) begin
      cov.push_back(8'h81); cov.push_back(8'h00);
      cov.push_back(vlan_ctl[15:8]); cov.push_back(vlan_ctl[7:0]);
    end
    lt = (type_override != 0) ? type_override : 16'(plen);
    cov.push_back(lt[15:8]); cov.push_back(lt[7:0]);
    for (int k = 0; k < plen; k++) cov.push_back(8'(k));
    lastpay = cov.size() - 1;
    if (pad_en && !data_only) while (cov.size() < 60) cov.push_back(8'h00);
    crc = 32'hFFFFFFFF;
    foreach (cov[i]) begin
      crc = crc ^ {24'h0, cov[i]};
      for (int b = 0; b < 8; b++) crc = crc[0] ? ((crc >> 1) ^ 32'hEDB88320) : (crc >> 1);
    end
    crc = ~crc;
    if (!data_only) begin
      for (int k = 0; k < int'(preamble_len); k++) begin
        fd.push_back(err_preamble ? 8'hAA : 8'h55); ft.push_back(err_preamble ? "R8" : "R1");
      end
      fd.push_back(8'hD5); ft.push_back("R1");
    end
    foreach (cov[i]) begin
      if (i == lastpay && plen > 0 && err_payload) begin fd.push_back(~cov[i]); ft.push_back("R8"); end
      else begin
        fd.push_back(cov[i]);
        ft.push_back(i < 12 ? "R4" : (i > lastpay ? "R5" : (vlan_en && i < 16 ? "R6" : "R2")));
      end
    end
    if (!data_only)
      for (int k = 0; k < 4; k++) begin
        fd.push_back(crc[8*k +: 8] ^ {8{err_crc}}); ft.push_back("R7");
      end
    if (err_late_end) begin fd.push_back(8'h00); ft.push_back("R9"); end
    push(8'h00, 1'b0, 1'b0, 1'b0, "R12");
    gapn = (int'(ipg_len) < 1) ? 1 : int'(ipg_len);
    foreach (fd[i]) push(fd[i], 1'b1, err_phy, (i == fd.size() - 1) && gapn == 1, ft[i]);
    for (int k = 1; k < gapn; k++) push(8'h00, 1'b0, 1'b0, k == gapn - 1, "R11");
  endtask

  task automatic launch();
    step();
    while (!last_rdy) step();
    start = 1'b1;
    model_frame();
    step();
    start = 1'b0;
  endtask

  task automatic drain();
    while (q_d.size() > 0) step();
    step();
  endtask

  task automatic defaults();
    dst_addr = 48'h0A1B2C3D4E5F; src_addr = 48'h665544332211;
    addr_msb_first = 0; preamble_len = 4'd7; len_start = 11'd46; len_step = 11'd10;
    len_max = 11'd70; type_override = 16'h0; pad_en = 1; vlan_en = 0; vlan_ctl = 16'h0;
    err_payload = 0; err_preamble = 0; err_crc = 0; err_phy = 0; err_late_end = 0;
    data_only = 0; ipg_len = 8'd12;
  endtask

  initial begin
    rst = 1'b1; start = 1'b0;
    defaults();
    repeat (4) step();                 // R13 reset state
    rst = 1'b0;
    step();
    in_reset = 1'b0;
    // R2 length sequence 46,56,66,0,10 with R1 layout and R5 padding at length 0
    repeat (5) launch();
    drain();
    // R4 high-first addresses, R3 type override
    addr_msb_first = 1; type_override = 16'h88B5; launch(); drain();
    defaults();
    // R6 VLAN tag with padding, then without padding
    vlan_en = 1; vlan_ctl = 16'hA00C; launch(); pad_en = 0; launch(); drain();
    defaults();
    // R8 payload and preamble faults, R7 inverted check field
    err_payload = 1; err_preamble = 1; err_crc = 1; launch(); drain();
    defaults();
    // R9 error strobe and late valid drop
    err_phy = 1; err_late_end = 1; launch(); drain();
    defaults();
    // R10 data-only, with and without late end
    data_only = 1; err_late_end = 1; launch(); err_late_end = 0; launch(); drain();
    defaults();
    // R11 gaps of 0, 1 and 3 back to back; R1 zero preamble
    ipg_len = 0; launch(); launch();
    ipg_len = 1; launch(); launch();
    ipg_len = 3; launch(); launch();
    preamble_len = 0; launch(); drain();
    defaults();
    // R12 inputs changed after acceptance; R11 start ignored while ready low
    launch();
    dst_addr = 48'hFFEEDDCCBBAA; err_phy = 1; ipg_len = 8'd2; vlan_en = 1;
    start = 1'b1;
    repeat (3) step();
    start = 1'b0;
    drain();
    repeat (3) step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule